// File: doc/BRIEF.md
# Paired Doubleword Load Sequencer

This block sits beside the load/store path of a 64-bit core. It watches the instruction stream for one 32-bit load-pair encoding. When it sees one, it turns that instruction into two doubleword reads from memory. The first read comes from the effective address and goes to register `rd`. The second comes from the effective address plus eight bytes and goes to register `rd+1`.

The effective address is the sign-extended 12-bit offset added to the base register. The block reads the base register at the moment it accepts the instruction and keeps that value for both reads. Before any memory traffic starts, it checks three things:

- that 64-bit operation is enabled;
- that the operand combination is legal;
- that the address is aligned, when strict alignment is selected.

Each read waits on a request/acknowledge handshake of any length. A fault on either read ends the sequence at once and reports a cause code. The surrounding pipeline then re-presents the same instruction, and the block starts again from the first read.

Top module: `ldpair_seq`

## Requirements
- R1: An instruction is recognised only if bits 31:26 equal 001000 and bits 15:12 equal 0100. The other fields are `rd` in bits 25:21, base in bits 20:16 and a signed offset in bits 11:0. Any other word presented with `instr_valid` is ignored: `busy` stays low, no memory request is made and no exception is raised.
- R2: The effective address (EA) is the 12-bit offset, sign-extended to 64 bits, plus `base_data`. The first read is issued at EA, and its response data is written to `rd` on the cycle after its acknowledge.
- R3: After the first read completes, a second read is issued at EA+8. Its data is written to `rd+1` on the cycle after its acknowledge.
- R4: `mem_req` stays high with an unchanged `mem_addr` until `mem_ack` is seen, for any number of wait cycles.
- R5: If `en64` is low when a recognised instruction is accepted, cause 1 (reserved instruction) is raised and no read is issued. This check has the highest priority.
- R6: If `rd` is 31, or `rd` equals base, cause 4 (illegal operand) is raised and no read is issued. This check ranks below R5.
- R7: If `strict_align` is high and any of EA bits 2:0 is nonzero, cause 2 (address error) is raised and no read is issued. This check ranks below R6. With `strict_align` low, a misaligned EA is read as-is at EA and at EA+8.
- R8: A response with `mem_ack` and `mem_err` both high on either read raises cause 3 (bus error). That read writes nothing, no further request follows, and the block returns to idle. A re-presented instruction restarts from the read at EA.
- R9: `busy` is high from the cycle after acceptance through the cycle of the second write-back, and low otherwise. Instructions presented while `busy` is high are ignored.
- R10: `exc_valid` is a one-cycle pulse on the cycle after the faulting event, carrying a nonzero `exc_cause`. `exc_cause` reads 0 whenever `exc_valid` is low. A write and an exception never occur on the same cycle.
- R11: The base value is captured at acceptance. Later changes on `base_data` do not move either read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| en64 | input | 1 | 64-bit operations enabled |
| strict_align | input | 1 | Enforce natural doubleword alignment |
| base_idx | output | 5 | Base register index for the register read |
| base_data | input | 64 | Base register value |
| mem_req | output | 1 | Read request |
| mem_addr | output | 64 | Read byte address |
| mem_ack | input | 1 | Read response strobe |
| mem_err | input | 1 | Response is a fault (valid with mem_ack) |
| mem_rdata | input | 64 | Response data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 64 | Register-file write data |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 3 | 0 none, 1 reserved, 2 address, 3 bus, 4 illegal operand |
| busy | output | 1 | Sequence in progress |

## Verification
The hardest case to reach is a fault on the second read, after `rd` has already been written, followed by a clean restart. The bench builds it by answering the first request normally and then flagging the second response as an error. It then re-presents the same word with a different memory latency. It checks that the first new request returns to EA and that both registers are written again. A second hard case is a new instruction arriving while a read is still outstanding. The bench holds back the memory acknowledge and drives `instr_valid` during that wait.

// File: rtl/ldpair_pkg.sv
// Package: shared encodings for the paired doubleword load sequencer.
// Assumes a 32-bit instruction word with fixed field positions.
package ldpair_pkg;
    localparam int REG_IDX_W = 5;
    localparam int OFF_W     = 12;
    localparam logic [5:0] MAJOR_OP = 6'b001000;
    localparam logic [3:0] MINOR_OP = 4'b0100;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_RSVD = 3'd1,
        CAUSE_ADDR = 3'd2,
        CAUSE_BUS  = 3'd3,
        CAUSE_OPND = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD0,
        ST_LOAD1,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic                 hit;
        logic [REG_IDX_W-1:0] rd;
        logic [REG_IDX_W-1:0] base;
        logic [OFF_W-1:0]     offset;
        logic                 opnd_bad;
    } ldp_fields_t;
endpackage

// File: rtl/ldpair_decode.sv
// Module: ldpair_decode
// Splits the instruction word into fields and flags opcode hit and illegal operands.
// Assumes the field layout fixed in ldpair_pkg; purely combinational.
module ldpair_decode
    import ldpair_pkg::*;
(
    input  logic [31:0]  instr_word,
    output ldp_fields_t  fields
);
    // Field extraction, opcode match and operand legality.
    always_comb begin
        fields.hit      = (instr_word[31:26] == MAJOR_OP) && (instr_word[15:12] == MINOR_OP);
        fields.rd       = instr_word[25:21];
        fields.base     = instr_word[20:16];
        fields.offset   = instr_word[11:0];
        fields.opnd_bad = (instr_word[25:21] == '1) || (instr_word[25:21] == instr_word[20:16]);
    end
endmodule

// File: rtl/ldpair_agen.sv
// Module: ldpair_agen
// Forms the effective address from a base value and a signed offset, and
// reports misalignment when strict alignment is requested.
// Assumes ALIGN_BITS low address bits must be zero for a naturally aligned access.
module ldpair_agen #(
    parameter int DATA_W     = 64,
    parameter int OFF_W      = 12,
    parameter int ALIGN_BITS = 3
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFF_W-1:0]  offset,
    input  logic              strict_align,
    output logic [DATA_W-1:0] ea,
    output logic              misaligned
);
    localparam int EXT_W = DATA_W - OFF_W;

    // Sign-extend the offset and add it to the base.
    always_comb begin
        ea         = base_val + {{EXT_W{offset[OFF_W-1]}}, offset};
        misaligned = strict_align && (|ea[ALIGN_BITS-1:0]);
    end
endmodule

// File: rtl/ldpair_fsm.sv
// Module: ldpair_fsm
// Sequences the two reads, issues write-backs and raises exceptions.
// Assumes decode and address inputs are valid in the acceptance cycle only;
// everything needed later is captured on acceptance.
module ldpair_fsm
    import ldpair_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  ldp_fields_t          fields,
    input  logic                 en64,
    input  logic [DATA_W-1:0]    ea,
    input  logic                 misaligned,
    output logic                 mem_req,
    output logic [DATA_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic                 mem_err,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic                 exc_valid,
    output cause_e               exc_cause,
    output logic                 busy
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

    state_e               state;
    logic [DATA_W-1:0]    ea_q;
    logic [REG_IDX_W-1:0] rd_q;

    // Request outputs: address follows the active read.
    always_comb begin
        mem_req  = (state == ST_LOAD0) || (state == ST_LOAD1);
        mem_addr = (state == ST_LOAD1) ? ea_q + STEP : ea_q;
        busy     = (state != ST_IDLE);
    end

    // State, capture registers, write-back and exception pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ea_q      <= '0;
            rd_q      <= '0;
            rf_we     <= 1'b0;
            rf_waddr  <= '0;
            rf_wdata  <= '0;
            exc_valid <= 1'b0;
            exc_cause <= CAUSE_NONE;
        end else begin
            rf_we     <= 1'b0;
            exc_valid <= 1'b0;
            exc_cause <= CAUSE_NONE;
            case (state)
                ST_IDLE: begin
                    if (instr_valid && fields.hit) begin
                        if (!en64) begin
                            exc_valid <= 1'b1;
                            exc_cause <= CAUSE_RSVD;
                        end else if (fields.opnd_bad) begin
                            exc_valid <= 1'b1;
                            exc_cause <= CAUSE_OPND;
                        end else if (misaligned) begin
                            exc_valid <= 1'b1;
                            exc_cause <= CAUSE_ADDR;
                        end else begin
                            ea_q  <= ea;
                            rd_q  <= fields.rd;
                            state <= ST_LOAD0;
                        end
                    end
                end
                ST_LOAD0, ST_LOAD1: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            exc_valid <= 1'b1;
                            exc_cause <= CAUSE_BUS;
                            state     <= ST_IDLE;
                        end else begin
                            rf_we    <= 1'b1;
                            rf_wdata <= mem_rdata;
                            if (state == ST_LOAD0) begin
                                rf_waddr <= rd_q;
                                state    <= ST_LOAD1;
                            end else begin
                                rf_waddr <= rd_q + 1'b1;
                                state    <= ST_DONE;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ldpair_seq.sv
// Module: ldpair_seq (top)
// Paired doubleword load sequencer: decode, address generation and read sequencing.
// Assumes base_data answers base_idx combinationally in the same cycle.
module ldpair_seq
    import ldpair_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ALIGN_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [31:0]          instr_word,
    input  logic                 en64,
    input  logic                 strict_align,
    output logic [REG_IDX_W-1:0] base_idx,
    input  logic [DATA_W-1:0]    base_data,
    output logic                 mem_req,
    output logic [DATA_W-1:0]    mem_addr,
    input  logic                 mem_ack,
    input  logic                 mem_err,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic                 exc_valid,
    output logic [2:0]           exc_cause,
    output logic                 busy
);
    ldp_fields_t       fields;
    logic [DATA_W-1:0] ea;
    logic              misaligned;
    cause_e            cause;

    ldpair_decode u_dec (
        .instr_word (instr_word),
        .fields     (fields)
    );

    ldpair_agen #(.DATA_W(DATA_W), .OFF_W(OFF_W), .ALIGN_BITS(ALIGN_BITS)) u_agen (
        .base_val     (base_data),
        .offset       (fields.offset),
        .strict_align (strict_align),
        .ea           (ea),
        .misaligned   (misaligned)
    );

    ldpair_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .fields      (fields),
        .en64        (en64),
        .ea          (ea),
        .misaligned  (misaligned),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err),
        .mem_rdata   (mem_rdata),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .exc_valid   (exc_valid),
        .exc_cause   (cause),
        .busy        (busy)
    );

    // Drive the base register index and the cause code out of the block.
    always_comb begin
        base_idx  = fields.base;
        exc_cause = cause;
    end
endmodule

// File: rtl/ldpair_seq_chk.sv
// Module: ldpair_seq_chk
// Port-level protocol checks for ldpair_seq, attached with bind.
// Assumes the same parameter defaults as the top module.
module ldpair_seq_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [31:0]       instr_word,
    input logic              mem_req,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              mem_err,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              rf_we,
    input logic [DATA_W-1:0] rf_wdata,
    input logic              exc_valid,
    input logic [2:0]        exc_cause,
    input logic              busy
);
    logic opc_miss;
    assign opc_miss = (instr_word[31:26] != 6'b001000) || (instr_word[15:12] != 4'b0100);

    AST_IGNORE_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && opc_miss && !busy |=> !busy && !exc_valid); // R1
    AST_ACK_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_err |=> rf_we && (rf_wdata == $past(mem_rdata))); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R4
    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_err |=> !mem_req && exc_valid && (exc_cause == 3'd3) && !rf_we); // R8
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R9
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_cause != 3'd0) && (exc_cause <= 3'd4)); // R10
    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> (exc_cause == 3'd0)); // R10
    AST_WE_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && exc_valid)); // R10
endmodule

bind ldpair_seq ldpair_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .mem_rdata   (mem_rdata),
    .rf_we       (rf_we),
    .rf_wdata    (rf_wdata),
    .exc_valid   (exc_valid),
    .exc_cause   (exc_cause),
    .busy        (busy)
);

// File: tb/ldpair_seq_tb.sv
// Directed bench for ldpair_seq: one task per scenario, each checking its own results.
module ldpair_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        en64 = 1'b1;
    logic        strict_align = 1'b1;
    logic [4:0]  base_idx;
    logic [63:0] base_data = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [63:0] rf_wdata;
    logic        exc_valid;
    logic [2:0]  exc_cause;
    logic        busy;

    int checks = 0;
    int errors = 0;

    // Logs filled by the monitor and the responder.
    int          wr_cnt, exc_cnt, req_cyc, nreq, stab_bad;
    logic [4:0]  wr_idx  [0:3];
    logic [63:0] wr_dat  [0:3];
    logic [2:0]  exc_last;
    logic [63:0] req_addr [0:1];
    logic        busy_after;

    always #5 clk = ~clk;

    ldpair_seq dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .en64(en64), .strict_align(strict_align), .base_idx(base_idx), .base_data(base_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .busy(busy)
    );

    function automatic logic [31:0] enc(input logic [4:0] rd, input logic [4:0] bs, input logic [11:0] off);
        return {6'b001000, rd, bs, 4'b0100, off};
    endfunction

    function automatic logic [63:0] mdata(input logic [63:0] a);
        return a ^ 64'h5A5A_0F0F_1234_8765;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: log write-backs, exception pulses and request cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_we && wr_cnt < 4) begin
                wr_idx[wr_cnt] = rf_waddr;
                wr_dat[wr_cnt] = rf_wdata;
            end
            if (rf_we) wr_cnt++;
            if (exc_valid) begin
                exc_cnt++;
                exc_last = exc_cause;
            end
            if (mem_req) req_cyc++;
        end
    end

    // Present one word, then serve up to nload reads; errat selects a faulting read (-1 none).
    task automatic run_ldp(input logic [31:0] w, input logic [63:0] bv, input int nload,
                           input int lat0, input int lat1, input int errat, input bit inject);
        @(negedge clk);
        wr_cnt = 0; exc_cnt = 0; req_cyc = 0; nreq = 0; stab_bad = 0; exc_last = 0;
        instr_word = w; base_data = bv; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        base_data = ~bv;
        busy_after = busy;
        for (int k = 0; k < nload; k++) begin
            int wt = 0;
            while (!mem_req && wt < 10) begin
                @(negedge clk);
                wt++;
            end
            if (!mem_req) break;
            req_addr[k] = mem_addr;
            nreq++;
            for (int j = 0; j < ((k == 0) ? lat0 : lat1); j++) begin
                if (inject && j == 0) begin
                    instr_word = enc(5'd9, 5'd2, 12'h040);
                    base_data = 64'h8000;
                    instr_valid = 1'b1;
                end
                @(negedge clk);
                instr_valid = 1'b0;
                if (!mem_req || mem_addr != req_addr[k]) stab_bad++;
            end
            mem_ack = 1'b1;
            mem_err = (errat == k);
            mem_rdata = mdata(req_addr[k]);
            @(negedge clk);
            mem_ack = 1'b0;
            mem_err = 1'b0;
            if (errat == k) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !mem_req && !rf_we, "R9 reset idle", {61'b0, busy, mem_req, rf_we}, 0);
        chk(!exc_valid && exc_cause == 0, "R10 reset no exception", {60'b0, exc_valid, exc_cause}, 0);
    endtask

    task automatic t_basic();
        run_ldp(enc(5'd4, 5'd7, 12'h010), 64'h1000, 2, 0, 0, -1, 0);
        chk(busy_after, "R9 busy after accept", busy_after, 1);
        chk(req_addr[0] == 64'h1010, "R2 first address", req_addr[0], 64'h1010);
        chk(req_addr[1] == 64'h1018, "R3 second address (R11 base captured)", req_addr[1], 64'h1018);
        chk(wr_cnt == 2, "R3 two write-backs", wr_cnt, 2);
        chk(wr_idx[0] == 5'd4 && wr_dat[0] == mdata(64'h1010), "R2 write rd", wr_dat[0], mdata(64'h1010));
        chk(wr_idx[1] == 5'd5 && wr_dat[1] == mdata(64'h1018), "R3 write rd+1", wr_dat[1], mdata(64'h1018));
        chk(!busy && exc_cnt == 0, "R9 idle after done", busy, 0);
    endtask

    task automatic t_negoff_latency();
        run_ldp(enc(5'd10, 5'd3, 12'hFF8), 64'h2000, 2, 3, 5, -1, 0);
        chk(req_addr[0] == 64'h1FF8, "R2 negative offset", req_addr[0], 64'h1FF8);
        chk(req_addr[1] == 64'h2000, "R3 second after wait", req_addr[1], 64'h2000);
        chk(stab_bad == 0, "R4 request held stable", stab_bad, 0);
        chk(wr_cnt == 2 && wr_idx[1] == 5'd11, "R3 write rd+1 after wait", wr_idx[1], 11);
    endtask

    task automatic t_foreign();
        run_ldp({6'b001001, 5'd4, 5'd7, 4'b0100, 12'h0}, 64'h100, 0, 0, 0, -1, 0);
        chk(!busy_after && req_cyc == 0 && exc_cnt == 0, "R1 major mismatch ignored", req_cyc, 0);
        run_ldp({6'b001000, 5'd4, 5'd7, 4'b0101, 12'h0}, 64'h100, 0, 0, 0, -1, 0);
        chk(!busy_after && req_cyc == 0 && exc_cnt == 0, "R1 minor mismatch ignored", req_cyc, 0);
    endtask

    task automatic t_rsvd();
        en64 = 1'b0;
        run_ldp(enc(5'd4, 5'd7, 12'h0), 64'h100, 0, 0, 0, -1, 0);
        chk(exc_cnt == 1 && exc_last == 3'd1 && req_cyc == 0, "R5 reserved instruction", exc_last, 1);
        chk(exc_cnt == 1, "R10 single pulse", exc_cnt, 1);
        run_ldp(enc(5'd31, 5'd7, 12'h0), 64'h100, 0, 0, 0, -1, 0);
        chk(exc_last == 3'd1, "R5 priority over operand check", exc_last, 1);
        en64 = 1'b1;
    endtask

    task automatic t_opnd();
        run_ldp(enc(5'd31, 5'd7, 12'h0), 64'h100, 0, 0, 0, -1, 0);
        chk(exc_last == 3'd4 && req_cyc == 0 && !busy_after, "R6 rd is 31", exc_last, 4);
        run_ldp(enc(5'd6, 5'd6, 12'h0), 64'h100, 0, 0, 0, -1, 0);
        chk(exc_last == 3'd4 && req_cyc == 0, "R6 rd equals base", exc_last, 4);
        run_ldp(enc(5'd6, 5'd6, 12'h003), 64'h100, 0, 0, 0, -1, 0);
        chk(exc_last == 3'd4, "R6 priority over alignment", exc_last, 4);
    endtask

    task automatic t_align();
        run_ldp(enc(5'd1, 5'd2, 12'h004), 64'h300, 0, 0, 0, -1, 0);
        chk(exc_last == 3'd2 && req_cyc == 0 && wr_cnt == 0, "R7 misaligned faults", exc_last, 2);
        strict_align = 1'b0;
        run_ldp(enc(5'd1, 5'd2, 12'h004), 64'h300, 2, 1, 0, -1, 0);
        chk(exc_cnt == 0 && req_addr[0] == 64'h304 && req_addr[1] == 64'h30C,
            "R7 relaxed misaligned reads", req_addr[1], 64'h30C);
        strict_align = 1'b1;
    endtask

    task automatic t_fault_restart();
        run_ldp(enc(5'd12, 5'd1, 12'h020), 64'h4000, 2, 1, 2, 1, 0);
        chk(exc_cnt == 1 && exc_last == 3'd3, "R8 fault on second read", exc_last, 3);
        chk(wr_cnt == 1 && nreq == 2 && !busy, "R8 no write for faulting read", wr_cnt, 1);
        run_ldp(enc(5'd12, 5'd1, 12'h020), 64'h4000, 2, 0, 1, -1, 0);
        chk(req_addr[0] == 64'h4020, "R8 restart from first read", req_addr[0], 64'h4020);
        chk(wr_cnt == 2 && wr_idx[0] == 5'd12 && wr_idx[1] == 5'd13, "R8 restart completes", wr_cnt, 2);
        run_ldp(enc(5'd12, 5'd1, 12'h020), 64'h4000, 2, 0, 0, 0, 0);
        chk(wr_cnt == 0 && exc_last == 3'd3 && req_cyc == 1, "R8 fault on first read", req_cyc, 1);
    endtask

    task automatic t_busy_ignore();
        run_ldp(enc(5'd20, 5'd8, 12'h000), 64'h6000, 2, 3, 0, -1, 1);
        chk(wr_cnt == 2 && exc_cnt == 0, "R9 instruction during busy ignored", wr_cnt, 2);
        chk(req_addr[1] == 64'h6008 && req_cyc == 5, "R9 no extra reads", req_cyc, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_negoff_latency();
        t_foreign();
        t_rsvd();
        t_opnd();
        t_align();
        t_fault_restart();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule